// File: doc/BRIEF.md
# Three-Modulus Residue-to-Binary Reconstruction Unit

This unit turns a residue triple, taken with respect to the pairwise coprime moduli 3, 5 and 7, back into the single integer it stands for in the ring of integers modulo 105. It sits at the output of a bank of small modular channels, after the computation is finished. Each new triple arrives with a valid strobe. The reconstructed value leaves the unit with its own strobe, two clock cycles later, and a new triple can be accepted on every clock.

Internally, each residue is scaled by a fixed combined weight. These weights are 70 for modulus 3, 21 for modulus 5 and 15 for modulus 7. The three products are added in a first pipeline stage. A second stage then brings the sum into the range 0 to 104 by conditional subtraction. The unit also checks every residue against its own modulus. If any residue is out of range, the unit raises an error flag and forces the result to zero. A combinational view of the registered result gives the centred signed reading, in which values above 52 stand for the value minus 105.

Top module: `crt105_recon`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `out_vld`, `out_err`, `out_val` and `out_sgn` all at 0.
- R2: For an accepted triple whose residues are all in range, `out_val` is the unique x in 0..104 that satisfies x mod 3 = `res3`, x mod 5 = `res5` and x mod 7 = `res7`.
- R3: Whenever `out_vld` is high, `out_val` is below 105.
- R4: `out_vld` rises exactly two clock edges after a triple is sampled with `in_vld` high. Back-to-back triples come out back-to-back, in the same order they went in.
- R5: An accepted triple is invalid if `res3` is 3, if `res5` is 5, 6 or 7, or if `res7` is 7. For an invalid triple, the matching output cycle has `out_err` = 1, `out_val` = 0 and `out_sgn` = 0.
- R6: `out_sgn` is a 7-bit two's complement value. It equals `out_val` when `out_val` is 52 or less, and `out_val` - 105 when `out_val` is 53 or more.
- R7: `out_err` is never high while `out_vld` is low.
- R8: Boundary cases: the triple (2,4,6) gives 104 with a signed reading of -1, (1,2,3) gives 52 with a signed reading of +52, (2,3,4) gives 53 with a signed reading of -52, and (0,0,0) gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Residue triple present this cycle |
| res3 | input | 2 | Residue with respect to modulus 3 |
| res5 | input | 3 | Residue with respect to modulus 5 |
| res7 | input | 3 | Residue with respect to modulus 7 |
| out_vld | output | 1 | Result present this cycle |
| out_val | output | 7 | Reconstructed value, 0..104 |
| out_sgn | output | 7 | Centred signed view of `out_val`, -52..52 |
| out_err | output | 1 | Accepted triple had an out-of-range residue |

## Verification
The state of the unit is only a two-deep pipeline, so any fault in it appears at the ports within two cycles of the triple that exposes it. A wrong weight or a wrong subtraction threshold gives a value whose residues disagree with the input triple. It can also give a value of 105 or more, which shows up on the next valid output. A delay fault in the strobe or the error path makes the result appear one cycle early or late, or leaves a stale error flag next to a good result. Comparing every cycle against a model that searches for the residue match catches each of these on the first triple that triggers it.

// File: rtl/crt_pkg.sv
// Shared constants and types for the modulo-105 reconstruction unit.
// Assumes the three moduli are pairwise coprime; the combined weights are
// derived here from the moduli rather than written in by hand.
package crt_pkg;

    localparam int M_A = 3;
    localparam int M_B = 5;
    localparam int M_C = 7;
    localparam int M_ALL = M_A * M_B * M_C;

    localparam int W_A = 2;
    localparam int W_B = 3;
    localparam int W_C = 3;
    localparam int W_OUT = $clog2(M_ALL);

    // Multiplicative inverse of a modulo m, found by search (m is small).
    function automatic int inv_mod(input int a, input int m);
        int r;
        r = 0;
        for (int k = 1; k < m; k++) begin
            if (((a * k) % m) == 1) r = k;
        end
        return r;
    endfunction

    localparam int WT_A = (M_ALL / M_A) * inv_mod((M_ALL / M_A) % M_A, M_A);
    localparam int WT_B = (M_ALL / M_B) * inv_mod((M_ALL / M_B) % M_B, M_B);
    localparam int WT_C = (M_ALL / M_C) * inv_mod((M_ALL / M_C) % M_C, M_C);

    // Worst-case weighted sum with in-range residues sets the sum width.
    localparam int SUM_MAX = WT_A * (M_A - 1) + WT_B * (M_B - 1) + WT_C * (M_C - 1);
    localparam int W_SUM = $clog2(SUM_MAX + 1);
    localparam int HALF = (M_ALL - 1) / 2;

    typedef struct packed {
        logic             vld;
        logic             err;
        logic [W_SUM-1:0] sum;
    } wsum_t;

endpackage

// File: rtl/crt_weight_stage.sv
// First pipeline stage: checks each residue against its modulus and forms
// the weighted sum of the three residues. Assumes the weights come from
// crt_pkg. An out-of-range triple is flagged and its sum is zeroed.
module crt_weight_stage
    import crt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [W_A-1:0] res_a,
    input  logic [W_B-1:0] res_b,
    input  logic [W_C-1:0] res_c,
    output wsum_t          stage_q
);

    logic             bad;
    logic [W_SUM-1:0] sum_d;

    // Range check of every residue against its own modulus.
    always_comb begin
        bad = (int'(res_a) >= M_A) || (int'(res_b) >= M_B) || (int'(res_c) >= M_C);
    end

    // Weighted sum; each term is widened to the full sum width first.
    always_comb begin
        sum_d = W_SUM'(res_a) * W_SUM'(WT_A)
              + W_SUM'(res_b) * W_SUM'(WT_B)
              + W_SUM'(res_c) * W_SUM'(WT_C);
    end

    // Stage register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= in_vld;
            stage_q.err <= in_vld && bad;
            stage_q.sum <= (in_vld && !bad) ? sum_d : '0;
        end
    end

endmodule

// File: rtl/crt_mod_reduce.sv
// Second pipeline stage: brings the weighted sum into 0..M_ALL-1 by at most
// one of two conditional subtractions (2*M_ALL or M_ALL). Assumes the sum
// never exceeds SUM_MAX, which is below 3*M_ALL for these moduli.
module crt_mod_reduce
    import crt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wsum_t            stage_d,
    output logic             vld_q,
    output logic             err_q,
    output logic [W_OUT-1:0] val_q
);

    localparam logic [W_SUM-1:0] ONE_M = W_SUM'(M_ALL);
    localparam logic [W_SUM-1:0] TWO_M = W_SUM'(2 * M_ALL);

    logic [W_SUM-1:0] red;

    // Choose the one subtraction that lands in range.
    always_comb begin
        if (stage_d.sum >= TWO_M)      red = stage_d.sum - TWO_M;
        else if (stage_d.sum >= ONE_M) red = stage_d.sum - ONE_M;
        else                           red = stage_d.sum;
    end

    // Output register; an error forces the value to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            err_q <= 1'b0;
            val_q <= '0;
        end else begin
            vld_q <= stage_d.vld;
            err_q <= stage_d.err;
            val_q <= stage_d.err ? '0 : red[W_OUT-1:0];
        end
    end

endmodule

// File: rtl/crt_sign_view.sv
// Combinational centred reading of a value in 0..M_ALL-1: values above HALF
// map to value - M_ALL in two's complement of the same width.
module crt_sign_view
    import crt_pkg::*;
(
    input  logic                    [W_OUT-1:0] val,
    output logic signed [W_OUT-1:0] sgn
);

    // Wrap the upper half of the ring to negative numbers.
    always_comb begin
        if (int'(val) > HALF) sgn = $signed(val - W_OUT'(M_ALL));
        else                  sgn = $signed(val);
    end

endmodule

// File: rtl/crt105_recon.sv
// Residue-to-binary reconstruction for moduli 3, 5 and 7 (range 0..104).
// Two-cycle pipeline, one triple per clock; synchronous active-low reset.
// Assumes upstream word lengths keep true results inside the ring.
module crt105_recon
    import crt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [W_A-1:0]          res3,
    input  logic [W_B-1:0]          res5,
    input  logic [W_C-1:0]          res7,
    output logic                    out_vld,
    output logic [W_OUT-1:0]        out_val,
    output logic signed [W_OUT-1:0] out_sgn,
    output logic                    out_err
);

    wsum_t stage1;

    crt_weight_stage u_weight (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .res_a   (res3),
        .res_b   (res5),
        .res_c   (res7),
        .stage_q (stage1)
    );

    crt_mod_reduce u_reduce (
        .clk     (clk),
        .rst_n   (rst_n),
        .stage_d (stage1),
        .vld_q   (out_vld),
        .err_q   (out_err),
        .val_q   (out_val)
    );

    crt_sign_view u_sign (
        .val (out_val),
        .sgn (out_sgn)
    );

endmodule

// File: rtl/crt105_recon_chk.sv
// Property checker for crt105_recon, attached through the bind below.
// A small counter of cycles since reset guards the latency property.
module crt105_recon_chk
    import crt_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic                    out_vld,
    input logic [W_OUT-1:0]        out_val,
    input logic signed [W_OUT-1:0] out_sgn,
    input logic                    out_err
);

    logic [1:0] since_rst;

    // Count clean edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_err && out_val == '0));

    assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (int'(out_val) < M_ALL));

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_val == '0 && out_sgn == '0));

    assert_sign_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((int'(out_val) > HALF) ? (int'(out_sgn) == int'(out_val) - M_ALL)
                                             : (int'(out_sgn) == int'(out_val))));

    assert_err_needs_vld_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !out_err);

endmodule

bind crt105_recon crt105_recon_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .out_vld (out_vld),
    .out_val (out_val),
    .out_sgn (out_sgn),
    .out_err (out_err)
);

// File: tb/crt105_recon_tb.sv
`timescale 1ns/1ps
module crt105_recon_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [1:0]        res3 = '0;
    logic [2:0]        res5 = '0;
    logic [2:0]        res7 = '0;
    logic              out_vld;
    logic [6:0]        out_val;
    logic signed [6:0] out_sgn;
    logic              out_err;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    crt105_recon u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .res3(res3), .res5(res5), .res7(res7),
        .out_vld(out_vld), .out_val(out_val), .out_sgn(out_sgn), .out_err(out_err)
    );

    // Reference: search 0..104 for the residue match; -1 marks an invalid triple.
    function automatic int ref_value(input int a, input int b, input int c);
        int r;
        r = -1;
        if (a < 3 && b < 5 && c < 7) begin
            for (int x = 0; x < 105; x++)
                if (x % 3 == a && x % 5 == b && x % 7 == c) r = x;
        end
        return r;
    endfunction

    // Two-deep model of the expected outputs.
    logic e1_v = 0, e2_v = 0, e1_e = 0, e2_e = 0;
    int   e1_x = 0, e2_x = 0;
    always @(posedge clk) begin
        int r;
        r = ref_value(int'(res3), int'(res5), int'(res7));
        if (!rst_n) begin
            e1_v <= 0; e1_e <= 0; e1_x <= 0;
            e2_v <= 0; e2_e <= 0; e2_x <= 0;
        end else begin
            e2_v <= e1_v; e2_e <= e1_e; e2_x <= e1_x;
            e1_v <= in_vld;
            e1_e <= in_vld && (r < 0);
            e1_x <= (in_vld && r >= 0) ? r : 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model, away from the clock edge.
    task automatic compare();
        int es;
        es = (e2_x > 52) ? e2_x - 105 : e2_x;
        chk("R4 out_vld", int'(out_vld), int'(e2_v));
        chk("R7/R5 out_err", int'(out_err), int'(e2_e));
        if (e2_v) begin
            chk(e2_e ? "R5 out_val" : "R2 out_val", int'(out_val), e2_x);
            chk("R3 range", int'(out_val) < 105 ? 1 : 0, 1);
            chk("R6 out_sgn", int'(out_sgn), es);
            if (!e2_e && (e2_x == 104 || e2_x == 52 || e2_x == 53 || e2_x == 0))
                chk("R8 boundary sign", int'(out_sgn), es);
        end
    endtask

    task automatic step(input logic v, input int a, input int b, input int c);
        @(negedge clk);
        compare();
        in_vld = v; res3 = 2'(a); res5 = 3'(b); res7 = 3'(c);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: hold reset with valid input present, then check cleared outputs.
        in_vld = 1; res3 = 2; res5 = 4; res7 = 6;
        repeat (3) @(negedge clk);
        chk("R1 out_vld", int'(out_vld), 0);
        chk("R1 out_err", int'(out_err), 0);
        chk("R1 out_val", int'(out_val), 0);
        rst_n = 1;
        in_vld = 0;
        // R8 boundaries, back to back (R4), then an idle cycle.
        step(1, 2, 4, 6);
        step(1, 1, 2, 3);
        step(1, 2, 3, 4);
        step(1, 0, 0, 0);
        step(0, 1, 1, 1);
        // R5: each kind of out-of-range residue, mixed with good triples.
        step(1, 3, 0, 0);
        step(1, 1, 5, 1);
        step(1, 1, 1, 7);
        step(1, 2, 7, 2);
        step(1, 1, 1, 1);
        step(0, 3, 7, 7);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // Full sweep of all in-range triples, strobe always high (R2).
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 7; c++)
                    step(1, a, b, c);
        // Random stream with gaps and occasional bad residues.
        for (int i = 0; i < 2000; i++)
            step(($urandom_range(0, 3) != 0), $urandom_range(0, 3),
                 $urandom_range(0, 7), $urandom_range(0, 7));
        // R1 again: reset in the middle of traffic.
        step(1, 2, 2, 2);
        @(negedge clk); compare(); rst_n = 0;
        @(negedge clk); compare();
        @(negedge clk);
        chk("R1 mid-run out_vld", int'(out_vld), 0);
        chk("R1 mid-run out_err", int'(out_err), 0);
        rst_n = 1; in_vld = 0;
        step(1, 1, 4, 6);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        finish_run();
    end

endmodule